// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block holds the eleven interrupt flags of a CAN controller. It watches the controller's status lines and event pulses: receive buffer full, three transmit buffer free bits, overrun, error and bus state, error-passive state, sleep with bus activity, lost arbitration, bus error and identifier received. Each flag has its own set rule. Some flags follow a level, some catch a rising edge and some catch a change in either direction. Every flag is also gated by its own bit of an enable word, and that enable is sampled in the cycle of the event.

Software reads the flag word over a single read strobe. The read returns the flags and clears them. The receive flag is the exception: it stays set for as long as its level condition holds. The block drives one interrupt request line, which is high whenever any flag is set. Edge and change detection compare each status input with a registered copy taken on the previous clock.

Top module: `can_irq_flags`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after a reset edge, every flag is 0, `rd_data` is 0 and `irq` is 0.
- R2: Flag bit 0 (receive) is set at the next clock edge whenever `rx_avail` and `irq_en[0]` are both 1. A read does not clear it while that condition holds, and a read clears it once the condition is gone.
- R3: Flag bits 1, 9 and 10 are set only on a 0-to-1 transition of `tx_free[0]`, `tx_free[1]` and `tx_free[2]` respectively, with the matching enable bit 1, 9 or 10 set. A status bit that stays high does not set its flag again after a read.
- R4: Flag bit 2 (error warning) is set on any change, rising or falling, of `err_stat` or of `bus_stat` while `irq_en[2]` is 1.
- R5: Flag bit 3 (overrun) is set on a 0-to-1 transition of `ovr_stat` while `irq_en[3]` is 1. A level that is held does not set it.
- R6: Flag bit 4 (wake-up) is set when `sleeping`, `bus_act` and `irq_en[4]` are all 1.
- R7: Flag bit 5 (error passive) is set on any change, in either direction, of `passive_st` while `irq_en[5]` is 1.
- R8: Flag bits 6, 7 and 8 are set by the pulses `arb_lost`, `bus_err` and `id_rcvd` respectively, each gated by enable bit 6, 7 or 8.
- R9: An event whose enable bit is 0 in the event cycle sets nothing. Clearing an enable bit leaves an already set flag at 1.
- R10: `rd_data[10:0]` carries the flags in the bit order given above, and `rd_data[31:11]` is always 0. A cycle with `rd_en` high clears every flag at the following edge, within the limits of R2 and R11.
- R11: An event that sets a flag in the same cycle as a clearing read wins, so the flag stays 1.
- R12: `irq` is 1 exactly when at least one flag bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_avail | input | 1 | Receive buffer holds a message |
| tx_free | input | 3 | Transmit buffer free bits; bit 0 is buffer 1 |
| ovr_stat | input | 1 | Receive overrun status |
| err_stat | input | 1 | Error counter warning status |
| bus_stat | input | 1 | Bus-off status |
| passive_st | input | 1 | Controller is error passive |
| sleeping | input | 1 | Controller is in sleep mode |
| bus_act | input | 1 | Bus activity detected |
| arb_lost | input | 1 | Pulse: arbitration lost while sending |
| bus_err | input | 1 | Pulse: bus error detected |
| id_rcvd | input | 1 | Pulse: identifier received |
| irq_en | input | 11 | Per-flag enable, same bit order as the flags |
| rd_en | input | 1 | Read strobe; clears the flags |
| rd_data | output | 32 | Flag word, zero-extended |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that every input is a clean synchronous level sampled at the rising clock edge. It also assumes that the status copies hold values sampled on earlier edges, so a change that happens while reset is low does not count as an edge once reset is released. The bench therefore holds all status and pulse inputs at 0 through every reset. It changes inputs only at the falling edge and holds each vector for exactly one clock, so every transition the bench intends as an edge is seen as one, and no other transition is.

// File: rtl/can_irq_pkg.sv
// Package: flag positions, widths and the bundled status type shared by
// the interrupt flag register and its submodules.
// Assumes: flag bit positions are fixed, because software decodes them.
package can_irq_pkg;

    localparam int NFLAG  = 11;   // number of interrupt flags
    localparam int NTXB   = 3;    // number of transmit buffers
    localparam int RD_W   = 32;   // bus read width

    // Flag bit positions (decoded by software, so kept fixed)
    localparam int F_RX   = 0;
    localparam int F_TX1  = 1;
    localparam int F_EW   = 2;
    localparam int F_OVR  = 3;
    localparam int F_WAKE = 4;
    localparam int F_PAS  = 5;
    localparam int F_ARB  = 6;
    localparam int F_BERR = 7;
    localparam int F_ID   = 8;
    localparam int F_TX2  = 9;
    localparam int F_TX3  = 10;

    // Status and event inputs bundled for the detector
    typedef struct packed {
        logic            rx_avail;
        logic [NTXB-1:0] tx_free;
        logic            ovr;
        logic            err;
        logic            bus;
        logic            passive;
        logic            sleeping;
        logic            bus_act;
        logic            arb_lost;
        logic            bus_err;
        logic            id_rcvd;
    } can_stat_t;

    // Map transmit buffer number (0-based) to its flag position
    function automatic int tx_flag_idx(input int b);
        if (b == 0)      return F_TX1;
        else if (b == 1) return F_TX2;
        else             return F_TX3;
    endfunction

endpackage

// File: rtl/can_irq_evt.sv
// Module: can_irq_evt
// Turns the status inputs into one set request per flag. Each request is
// a level, a rising edge or a change in either direction.
// Assumes: inputs are synchronous to clk. The previous-value copies follow
// the inputs on every clock, reset included, so a change made while reset
// is held never shows up as an event afterwards.
module can_irq_evt
    import can_irq_pkg::*;
(
    input  logic             clk,
    input  can_stat_t        stat,
    output logic [NFLAG-1:0] evt
);

    logic [NTXB-1:0] tx_q;
    logic            ovr_q;
    logic            err_q;
    logic            bus_q;
    logic            pas_q;

    // Keep a one-cycle-old copy of every edge- or change-sensitive status bit
    always_ff @(posedge clk) begin
        tx_q  <= stat.tx_free;
        ovr_q <= stat.ovr;
        err_q <= stat.err;
        bus_q <= stat.bus;
        pas_q <= stat.passive;
    end

    logic [NTXB-1:0] tx_rise;

    // Rising-edge detection for each transmit buffer
    for (genvar b = 0; b < NTXB; b++) begin : g_tx
        assign tx_rise[b] = stat.tx_free[b] & ~tx_q[b];
    end

    // Assemble the per-flag requests in register bit order
    always_comb begin
        evt          = '0;
        evt[F_RX]    = stat.rx_avail;
        for (int b = 0; b < NTXB; b++) begin
            evt[tx_flag_idx(b)] = tx_rise[b];
        end
        evt[F_EW]    = (stat.err ^ err_q) | (stat.bus ^ bus_q);
        evt[F_OVR]   = stat.ovr & ~ovr_q;
        evt[F_WAKE]  = stat.sleeping & stat.bus_act;
        evt[F_PAS]   = stat.passive ^ pas_q;
        evt[F_ARB]   = stat.arb_lost;
        evt[F_BERR]  = stat.bus_err;
        evt[F_ID]    = stat.id_rcvd;
    end

endmodule

// File: rtl/can_irq_flag_bank.sv
// Module: can_irq_flag_bank
// Holds the flag bits. A bit is set by a request whose enable is high in
// that cycle and cleared by a read. A set in the same cycle beats the clear.
// Assumes: the clear is a one-cycle strobe. Level-type requests re-assert
// themselves on every cycle, which keeps their flags alive across reads.
module can_irq_flag_bank #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    input  logic [W-1:0] en,
    input  logic         clr,
    output logic [W-1:0] flags
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic hit;
        assign hit = req[i] & en[i];

        // One flag: reset to 0, set wins over read-clear, else hold
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (hit)
                flags[i] <= 1'b1;
            else if (clr)
                flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/can_irq_rd_port.sv
// Module: can_irq_rd_port
// Presents the flag word on the read bus, zero-extended, and forms the
// interrupt request.
// Assumes: W <= DW.
module can_irq_rd_port #(
    parameter int W  = 11,
    parameter int DW = 32
) (
    input  logic [W-1:0]  flags,
    output logic [DW-1:0] rd_data,
    output logic          irq
);

    localparam int PAD = DW - W;

    // Zero-extend the flag word onto the bus
    assign rd_data = {{PAD{1'b0}}, flags};

    // Request is any flag set
    assign irq = |flags;

endmodule

// File: rtl/can_irq_flags.sv
// Module: can_irq_flags (top)
// CAN interrupt flag register. It joins the event detector, the flag bank
// and the read port.
// Assumes: all inputs are synchronous to clk, rst_n is synchronous and
// active low, and rd_en is high for one cycle per read.
module can_irq_flags
    import can_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_avail,
    input  logic [NTXB-1:0]  tx_free,
    input  logic             ovr_stat,
    input  logic             err_stat,
    input  logic             bus_stat,
    input  logic             passive_st,
    input  logic             sleeping,
    input  logic             bus_act,
    input  logic             arb_lost,
    input  logic             bus_err,
    input  logic             id_rcvd,
    input  logic [NFLAG-1:0] irq_en,
    input  logic             rd_en,
    output logic [RD_W-1:0]  rd_data,
    output logic             irq
);

    can_stat_t        stat;
    logic [NFLAG-1:0] evt;
    logic [NFLAG-1:0] flags;

    // Bundle the status pins for the detector
    always_comb begin
        stat.rx_avail = rx_avail;
        stat.tx_free  = tx_free;
        stat.ovr      = ovr_stat;
        stat.err      = err_stat;
        stat.bus      = bus_stat;
        stat.passive  = passive_st;
        stat.sleeping = sleeping;
        stat.bus_act  = bus_act;
        stat.arb_lost = arb_lost;
        stat.bus_err  = bus_err;
        stat.id_rcvd  = id_rcvd;
    end

    can_irq_evt u_evt (
        .clk  (clk),
        .stat (stat),
        .evt  (evt)
    );

    can_irq_flag_bank #(.W(NFLAG)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (evt),
        .en    (irq_en),
        .clr   (rd_en),
        .flags (flags)
    );

    can_irq_rd_port #(.W(NFLAG), .DW(RD_W)) u_rd (
        .flags   (flags),
        .rd_data (rd_data),
        .irq     (irq)
    );

endmodule

// File: rtl/can_irq_flags_chk.sv
// Module: can_irq_flags_chk
// Port-level properties of the interrupt flag register, attached by bind.
// Assumes: inputs are sampled at the rising edge of clk.
module can_irq_flags_chk
    import can_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rx_avail,
    input logic [NTXB-1:0]  tx_free,
    input logic             ovr_stat,
    input logic             err_stat,
    input logic             bus_stat,
    input logic             passive_st,
    input logic             arb_lost,
    input logic [NFLAG-1:0] irq_en,
    input logic             rd_en,
    input logic [RD_W-1:0]  rd_data,
    input logic             irq
);

    // R1: the first cycle after a reset edge shows an empty register
    a_r1_reset_clear: assert property (@(posedge clk)
        !$past(rst_n) |-> (rd_data == '0 && !irq));

    // R12: request line matches the OR of the flag field
    a_r12_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|rd_data[NFLAG-1:0]));

    // R10: upper bus bits stay zero
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RD_W-1:NFLAG] == '0);

    // R2: receive level with enable sets the flag next cycle
    a_r2_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_avail && irq_en[F_RX]) |=> rd_data[F_RX]);

    // R3: rising edge of buffer 1 status with enable sets its flag
    a_r3_tx1_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_free[0]) && irq_en[F_TX1]) |=> rd_data[F_TX1]);

    // R4: any change of error or bus status with enable sets the warning flag
    a_r4_ew_change: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en[F_EW] && (!$stable(err_stat) || !$stable(bus_stat)))
        |=> rd_data[F_EW]);

    // R5: overrun rising edge with enable sets its flag
    a_r5_ovr_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovr_stat) && irq_en[F_OVR]) |=> rd_data[F_OVR]);

    // R7: passive state change with enable sets its flag
    a_r7_pas_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(passive_st) && irq_en[F_PAS]) |=> rd_data[F_PAS]);

    // R11: arbitration-lost pulse sets its flag even against a read
    a_r11_set_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && irq_en[F_ARB] && rd_en) |=> rd_data[F_ARB]);

    // R9: a clear flag with its enable off stays clear
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en[F_OVR] && !rd_data[F_OVR]) |=> !rd_data[F_OVR]);

    // R10: a read with the enable off leaves the flag cleared
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !irq_en[F_ARB]) |=> !rd_data[F_ARB]);

endmodule

bind can_irq_flags can_irq_flags_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_avail   (rx_avail),
    .tx_free    (tx_free),
    .ovr_stat   (ovr_stat),
    .err_stat   (err_stat),
    .bus_stat   (bus_stat),
    .passive_st (passive_st),
    .arb_lost   (arb_lost),
    .irq_en     (irq_en),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .irq        (irq)
);

// File: tb/test_can_irq_flags.sv
// Bench for can_irq_flags: a walked vector table, then directed cases.
// Vector layout (36 bits), most significant first:
//   rx | tx[2:0] | ovr err bus pas slp act al be id | en[10:0] | rd | exp[10:0]
module test_can_irq_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_avail = 1'b0;
    logic [2:0]  tx_free = '0;
    logic        ovr_stat = 1'b0, err_stat = 1'b0, bus_stat = 1'b0;
    logic        passive_st = 1'b0, sleeping = 1'b0, bus_act = 1'b0;
    logic        arb_lost = 1'b0, bus_err = 1'b0, id_rcvd = 1'b0;
    logic [10:0] irq_en = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    can_irq_flags i_can_irq_flags (
        .clk(clk), .rst_n(rst_n), .rx_avail(rx_avail), .tx_free(tx_free),
        .ovr_stat(ovr_stat), .err_stat(err_stat), .bus_stat(bus_stat),
        .passive_st(passive_st), .sleeping(sleeping), .bus_act(bus_act),
        .arb_lost(arb_lost), .bus_err(bus_err), .id_rcvd(id_rcvd),
        .irq_en(irq_en), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    localparam int NV = 17;
    localparam logic [35:0] VEC [NV] = '{
        36'b1_000_000000000_11111111111_0_00000000001, // R2 rx level sets
        36'b1_000_000000000_11111111111_1_00000000001, // R2 read, level holds
        36'b0_000_000000000_11111111111_1_00000000000, // R2 level gone, read clears
        36'b0_001_000000000_11111111111_0_00000000010, // R3 buf1 rises
        36'b0_001_000000000_11111111111_1_00000000000, // R10 read clears
        36'b0_001_000000000_11111111111_0_00000000000, // R3 held high, no re-set
        36'b0_111_000000000_11111111111_0_11000000000, // R3 buf2/buf3 rise
        36'b0_111_010000000_11111111111_1_00000000100, // R4 err rises; read clears tx
        36'b0_111_011000000_11111111111_1_00000000100, // R11 bus change beats read
        36'b0_111_011000000_11111111111_1_00000000000, // R4 no change, cleared
        36'b0_111_001000000_11111111111_0_00000000100, // R4 err falls
        36'b0_111_101100000_11111111111_1_00000101000, // R5 ovr rise, R7 pas rise
        36'b0_111_101000000_11111111111_1_00000100000, // R7 pas fall, R5 held
        36'b0_111_101011111_00000000000_1_00000000000, // R9 events disabled
        36'b0_111_101011111_11111111111_0_00111010000, // R8 pulses, R6 wake
        36'b0_111_101000000_00000000000_0_00111010000, // R9 enables off, flags kept
        36'b0_111_101000000_00000000000_1_00000000000  // R10 read clears all
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2:      return "R2";
            3, 5, 6:      return "R3";
            4, 16:        return "R10";
            7, 9, 10:     return "R4";
            8:            return "R11";
            11:           return "R5";
            12:           return "R7";
            13, 15:       return "R9";
            default:      return "R8";
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [35:0] v, input string tag);
        @(negedge clk);
        rx_avail   = v[35];
        tx_free    = v[34:32];
        ovr_stat   = v[31];
        err_stat   = v[30];
        bus_stat   = v[29];
        passive_st = v[28];
        sleeping   = v[27];
        bus_act    = v[26];
        arb_lost   = v[25];
        bus_err    = v[24];
        id_rcvd    = v[23];
        irq_en     = v[22:12];
        rd_en      = v[11];
        @(posedge clk);
        #2;
        chk({21'b0, rd_data[10:0]}, {21'b0, v[10:0]}, tag, "flags");
        chk({11'b0, rd_data[31:11]}, 32'b0, "R10", "upper bits");
        chk({31'b0, irq}, {31'b0, |v[10:0]}, "R12", "irq");
    endtask

    task automatic quiet_inputs();
        rx_avail = 0; tx_free = '0; ovr_stat = 0; err_stat = 0; bus_stat = 0;
        passive_st = 0; sleeping = 0; bus_act = 0; arb_lost = 0; bus_err = 0;
        id_rcvd = 0; irq_en = '0; rd_en = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk(rd_data, 32'b0, "R1", "rd_data in reset");
        chk({31'b0, irq}, 32'b0, "R1", "irq in reset");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i], vec_tag(i));
        end

        // R3 fall is no event; then R9 buf1 edge with its enable off
        apply(36'b0_000_101000000_11111111111_0_00000000000, "R3");
        apply(36'b0_001_101000000_11111111101_0_00000000000, "R9");
        // R11 arbitration-lost pulse during a read
        apply(36'b0_001_101000100_11111111111_1_00001000000, "R11");
        apply(36'b0_001_101000000_11111111111_1_00000000000, "R10");
        // R8 bus-error pulse alone
        apply(36'b0_001_101000010_11111111111_0_00010000000, "R8");

        // R1: reset clears a set flag
        @(negedge clk);
        quiet_inputs();
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        chk(rd_data, 32'b0, "R1", "rd_data after reset");
        chk({31'b0, irq}, 32'b0, "R1", "irq after reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk(rd_data, 32'b0, "R1", "rd_data after release");

        finish_run();
    end

endmodule